// File: doc/BRIEF.md
# Counter Watch-Point Event Unit

This block sits beside a 16-bit signed up/down counter and watches its value for five watch-point conditions: reaching the low limit, reaching the high limit, equalling either of two programmable thresholds, and reaching zero. Each condition has its own enable bit. An enabled condition that fires is recorded in a sticky hit bit of a status word. Every enabled condition also sets one shared pending-interrupt bit for the unit, which is then gated by the unit's interrupt enable.

The counter is outside this block. It presents its current value together with a strobe that marks each cycle in which the value was updated. The status word also carries a 2-bit mode field. This field gives the sign of the count, and when the count sits at zero it records whether zero was reached from above or from below. The limits and thresholds are static configuration inputs. The event-enable vector is a small register loaded through a write strobe.

Top module: `wp_event_unit`

## Requirements
- R1: After reset, the status word reads 0, the pending bit and the interrupt output are 0, and the event-enable register holds 5'b10011. The enable bits are [0] low limit, [1] high limit, [2] threshold 0, [3] threshold 1 and [4] zero, so only the two limits and zero start enabled.
- R2: When `cnt_vld` is high and `cnt_val` becomes equal to a watch value (signed 16-bit), the matching hit bit is set at the next clock edge. The hit bits in `status` are [2] threshold 1, [3] threshold 0, [4] low limit, [5] high limit and [6] zero.
- R3: An event fires only when the count changes to the matching value. An update with `cnt_vld` high that repeats the previous count fires nothing, and an input value with `cnt_vld` low fires nothing.
- R4: A matching value whose enable bit is 0 sets neither its hit bit nor the pending bit.
- R5: Hit bits are sticky: they accumulate over several events and hold until a clear.
- R6: Any enabled event sets `irq_pend`. The output `irq` equals `irq_pend` AND `irq_en`.
- R7: A one-cycle `irq_clr` with no event in the same cycle clears `irq_pend` and all hit bits at the next edge.
- R8: When `irq_clr` and an enabled event fall in the same cycle, the event wins. `irq_pend` stays 1, and afterwards only the new event's hit bits are set.
- R9: On every update, `status[1:0]` becomes 3 if the new count is positive and 2 if it is negative.
- R10: On an update to zero, `status[1:0]` becomes 0 if the previous count was positive and 1 if it was negative. An update that keeps the count at zero leaves the mode unchanged.
- R11: With `en_we` high, `en_wdata` is loaded into the enable register at the edge, and it governs events from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current signed count |
| cnt_vld | input | 1 | Count update strobe |
| lo_lim | input | 16 | Signed low limit |
| hi_lim | input | 16 | Signed high limit |
| thr0 | input | 16 | Signed threshold 0 |
| thr1 | input | 16 | Signed threshold 1 |
| en_we | input | 1 | Enable-register write strobe |
| en_wdata | input | 5 | Event-enable write data |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Pending-interrupt clear pulse |
| status | output | 7 | {zero, hi, lo, thr0, thr1 hits, mode[1:0]} |
| irq_pend | output | 1 | Raw pending interrupt |
| irq | output | 1 | Gated interrupt |

## Verification
The interrupt clear and a fresh enabled event can land in the same cycle. The bench provokes this by pulsing `irq_clr` while a count update moves the value onto zero from a negative value. The result is judged by requiring that the pending bit stays set and that only the zero hit bit survives, together with the from-negative mode code. The mode update and the zero event also coincide in that cycle, so both are checked from one status read.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int NUM_EVT = 5;

    typedef enum logic [2:0] {
        EV_LO   = 3'd0,
        EV_HI   = 3'd1,
        EV_TH0  = 3'd2,
        EV_TH1  = 3'd3,
        EV_ZERO = 3'd4
    } evt_idx_e;

    typedef enum logic [1:0] {
        MD_ZERO_FROM_POS = 2'd0,
        MD_ZERO_FROM_NEG = 2'd1,
        MD_NEG           = 2'd2,
        MD_POS           = 2'd3
    } dir_mode_e;

    localparam logic [NUM_EVT-1:0] EN_RESET = 5'b10011;

    typedef struct packed {
        logic      zero_hit;
        logic      hi_hit;
        logic      lo_hit;
        logic      th0_hit;
        logic      th1_hit;
        dir_mode_e mode;
    } status_t;

    function automatic status_t pack_status(input dir_mode_e md, input logic [NUM_EVT-1:0] hits);
        status_t s;
        s.mode     = md;
        s.th1_hit  = hits[EV_TH1];
        s.th0_hit  = hits[EV_TH0];
        s.lo_hit   = hits[EV_LO];
        s.hi_hit   = hits[EV_HI];
        s.zero_hit = hits[EV_ZERO];
        return s;
    endfunction

endpackage

// File: rtl/wp_compare.sv
module wp_compare
    import wp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N     = NUM_EVT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          cnt,
    input  logic                      vld,
    input  logic [N-1:0][CNT_W-1:0]   tgt,
    output logic [N-1:0]              fire,
    output logic [CNT_W-1:0]          prev
);
    logic changed;

    always_ff @(posedge clk) begin
        if (rst)      prev <= '0;
        else if (vld) prev <= cnt;
    end

    assign changed = vld && (cnt != prev);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign fire[i] = changed && (cnt == tgt[i]);
    end

    AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        !vld |-> (fire == '0)); // R3
endmodule

// File: rtl/wp_dirmode.sv
module wp_dirmode
    import wp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             vld,
    input  logic [CNT_W-1:0] prev,
    output dir_mode_e        mode
);
    localparam int SB = CNT_W - 1;

    logic cnt_zero, prev_zero;
    dir_mode_e mode_nx;

    assign cnt_zero  = (cnt == '0);
    assign prev_zero = (prev == '0);

    always_comb begin
        mode_nx = mode;
        if (vld) begin
            if (!cnt_zero)      mode_nx = cnt[SB] ? MD_NEG : MD_POS;
            else if (!prev_zero) mode_nx = prev[SB] ? MD_ZERO_FROM_NEG : MD_ZERO_FROM_POS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MD_ZERO_FROM_POS;
        else     mode <= mode_nx;
    end

    AST_MODE_POS: assert property (@(posedge clk) disable iff (rst)
        (vld && !cnt[SB] && !cnt_zero) |=> (mode == MD_POS)); // R9
    AST_MODE_NEG: assert property (@(posedge clk) disable iff (rst)
        (vld && cnt[SB]) |=> (mode == MD_NEG)); // R9
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (vld && cnt_zero && prev_zero) |=> $stable(mode)); // R10
endmodule

// File: rtl/wp_latch.sv
module wp_latch
    import wp_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fire,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    input  logic         clr,
    output logic [N-1:0] hits,
    output logic         pend
);
    logic [N-1:0] en_q;
    logic [N-1:0] gated;
    logic         any_evt;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= EN_RESET;
        else if (en_we) en_q <= en_wdata;
    end

    assign gated   = fire & en_q;
    assign any_evt = |gated;

    always_ff @(posedge clk) begin
        if (rst) begin
            hits <= '0;
            pend <= 1'b0;
        end else if (clr) begin
            hits <= gated;
            pend <= any_evt;
        end else begin
            hits <= hits | gated;
            pend <= pend | any_evt;
        end
    end

    AST_HITS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!clr && !any_evt) |=> $stable(hits)); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr && !any_evt) |=> (hits == '0 && !pend)); // R7
    AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        any_evt |=> pend); // R8
    AST_NO_EVT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!pend && !any_evt) |=> !pend); // R4
endmodule

// File: rtl/wp_event_unit.sv
module wp_event_unit
    import wp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_vld,
    input  logic [CNT_W-1:0] lo_lim,
    input  logic [CNT_W-1:0] hi_lim,
    input  logic [CNT_W-1:0] thr0,
    input  logic [CNT_W-1:0] thr1,
    input  logic             en_we,
    input  logic [NUM_EVT-1:0] en_wdata,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic [6:0]       status,
    output logic             irq_pend,
    output logic             irq
);
    logic [NUM_EVT-1:0][CNT_W-1:0] tgt;
    logic [NUM_EVT-1:0]            fire;
    logic [NUM_EVT-1:0]            hits;
    logic [CNT_W-1:0]              prev;
    dir_mode_e                     mode;

    always_comb begin
        tgt          = '0;
        tgt[EV_LO]   = lo_lim;
        tgt[EV_HI]   = hi_lim;
        tgt[EV_TH0]  = thr0;
        tgt[EV_TH1]  = thr1;
        tgt[EV_ZERO] = '0;
    end

    wp_compare #(.CNT_W(CNT_W), .N(NUM_EVT)) u_cmp (
        .clk(clk), .rst(rst), .cnt(cnt_val), .vld(cnt_vld),
        .tgt(tgt), .fire(fire), .prev(prev)
    );

    wp_dirmode #(.CNT_W(CNT_W)) u_dir (
        .clk(clk), .rst(rst), .cnt(cnt_val), .vld(cnt_vld),
        .prev(prev), .mode(mode)
    );

    wp_latch #(.N(NUM_EVT)) u_lat (
        .clk(clk), .rst(rst), .fire(fire), .en_we(en_we),
        .en_wdata(en_wdata), .clr(irq_clr), .hits(hits), .pend(irq_pend)
    );

    assign status = pack_status(mode, hits);
    assign irq    = irq_pend & irq_en;

    AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_pend && irq_en)); // R6
    AST_HIT_IMPLIES_PEND: assert property (@(posedge clk) disable iff (rst)
        (status[6:2] != '0) |-> irq_pend); // R6
endmodule

// File: tb/wp_event_unit_test.sv
`timescale 1ns/1ps
module wp_event_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cnt_val, lo_lim, hi_lim, thr0, thr1;
    logic        cnt_vld, en_we, irq_en, irq_clr;
    logic [4:0]  en_wdata;
    logic [6:0]  status;
    logic        irq_pend, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wp_event_unit uut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_vld(cnt_vld),
        .lo_lim(lo_lim), .hi_lim(hi_lim), .thr0(thr0), .thr1(thr1),
        .en_we(en_we), .en_wdata(en_wdata), .irq_en(irq_en),
        .irq_clr(irq_clr), .status(status), .irq_pend(irq_pend), .irq(irq)
    );

    task automatic check(input string req, input logic [6:0] exp_st,
                         input logic exp_p, input logic exp_i);
        n_chk++;
        if (status !== exp_st || irq_pend !== exp_p || irq !== exp_i) begin
            n_bad++;
            $display("FAIL %s: status=%h pend=%b irq=%b expected status=%h pend=%b irq=%b",
                     req, status, irq_pend, irq, exp_st, exp_p, exp_i);
        end
    endtask

    // one cycle of stimulus: applied at a falling edge, sampled at the next one
    task automatic step(input logic [15:0] c, input logic v, input logic clr);
        cnt_val = c; cnt_vld = v; irq_clr = clr;
        @(negedge clk);
        cnt_vld = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic t_reset_defaults;
        check("R1 reset", 7'h00, 1'b0, 1'b0);
        step(16'd10, 1'b1, 1'b0);            // high limit, enabled by default
        check("R1 R2 R6 hi default", 7'h23, 1'b1, 1'b1);
        step(16'd3, 1'b1, 1'b0);             // thr0 disabled at reset
        check("R4 thr0 disabled", 7'h23, 1'b1, 1'b1);
        step(16'd3, 1'b0, 1'b1);
        check("R7 clear", 7'h03, 1'b0, 1'b0);
    endtask

    task automatic t_enable_write;
        en_wdata = 5'b11111; en_we = 1'b1;
        @(negedge clk);
        en_we = 1'b0;
        step(16'd4, 1'b1, 1'b0);
        step(16'd3, 1'b1, 1'b0);
        check("R11 R2 thr0 enabled", 7'h0B, 1'b1, 1'b1);
        step(16'd3, 1'b0, 1'b1);
        step(16'd3, 1'b1, 1'b0);             // repeat value
        check("R3 held value", 7'h03, 1'b0, 1'b0);
        step(16'd10, 1'b0, 1'b0);            // no strobe
        check("R3 no strobe", 7'h03, 1'b0, 1'b0);
    endtask

    task automatic t_signed_and_overlap;
        step(16'hFFFE, 1'b1, 1'b0);          // -2 : thr1
        check("R2 R9 thr1 neg", 7'h06, 1'b1, 1'b1);
        step(16'hFFFB, 1'b1, 1'b0);          // -5 : low limit
        check("R5 R2 accumulate lo", 7'h16, 1'b1, 1'b1);
        step(16'd0, 1'b1, 1'b1);             // clear together with zero event
        check("R8 R10 clr vs zero from neg", 7'h41, 1'b1, 1'b1);
        step(16'd0, 1'b0, 1'b1);
        check("R7 clear again", 7'h01, 1'b0, 1'b0);
        step(16'd0, 1'b1, 1'b0);
        check("R10 R3 zero held", 7'h01, 1'b0, 1'b0);
        step(16'd4, 1'b1, 1'b0);
        check("R9 positive", 7'h03, 1'b0, 1'b0);
        step(16'd0, 1'b1, 1'b0);
        check("R10 zero from pos", 7'h40, 1'b1, 1'b1);
    endtask

    task automatic t_irq_gate;
        irq_en = 1'b0;
        #1;
        check("R6 gated off", 7'h40, 1'b1, 1'b0);
        irq_en = 1'b1;
        step(16'd0, 1'b0, 1'b1);
        check("R7 final clear", 7'h00, 1'b0, 1'b0);
        en_wdata = 5'b00000; en_we = 1'b1;
        @(negedge clk);
        en_we = 1'b0;
        step(16'd10, 1'b1, 1'b0);
        check("R4 R11 all disabled", 7'h03, 1'b0, 1'b0);
    endtask

    initial begin
        rst = 1'b1; cnt_val = '0; cnt_vld = 1'b0; en_we = 1'b0; en_wdata = '0;
        irq_en = 1'b1; irq_clr = 1'b0;
        lo_lim = 16'hFFFB; hi_lim = 16'd10; thr0 = 16'd3; thr1 = 16'hFFFE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_defaults();
        t_enable_write();
        t_signed_and_overlap();
        t_irq_gate();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule